// File: doc/BRIEF.md
# Supervisor Access Permission Checker

This block is the permission stage that sits after address translation in a simple paged processor. Each cycle it may accept one memory access request. A request carries the current privilege, the kind of access, a tag that says whether the access is explicit or implicit, the virtual address, and the attributes of the translated page. The block decides whether the access is granted or raises a page fault. The decision depends on the request, on a control word, on a no-execute enable and on an internal override flag.

Three protections apply to supervisor mode. The first is data-access prevention: supervisor code may not touch user pages unless the access is explicit and the override flag is set. The second is execution prevention: supervisor code may not fetch instructions from user pages. The third is no-execute, which blocks fetches from pages marked execute-disable. On a fault the block returns a 7-bit error code and captures the faulting virtual address. That address is held until the next fault. The override flag can be set or cleared only by supervisor-mode requests.

Results are registered and returned one cycle after acceptance through a valid/ready handshake.

Top module: `sup_perm_check`

## Requirements
- R1: A request to a page with present = 0 faults with error bit 0 = 0, whatever every other input is.
- R2: In user mode (`user_mode_i` = 1), an access to a page with user attribute 0 faults. A write (`kind_i` = 2'b01) to a user page with read/write attribute 0 also faults.
- R3: When control word bit 21 is 0, supervisor reads and writes to present user pages are granted.
- R4: When control word bit 21 is 1, an explicit (`implicit_i` = 0) supervisor read or write to a user page is granted only if the override flag is 1. Otherwise it faults.
- R5: When control word bit 21 is 1, an implicit (`implicit_i` = 1) supervisor read or write to a user page faults, whatever the value of the override flag.
- R6: When control word bit 20 is 1, a supervisor instruction fetch (`kind_i` = 2'b10) from a user page faults. When bit 20 is 0, that fetch is not blocked by this rule.
- R7: When `nx_en_i` = 1, a fetch from a page with execute-disable = 1 faults in either mode. When `nx_en_i` = 0, the execute-disable attribute has no effect.
- R8: The error code of a fault has these bits: bit 0 = page present, bit 1 = 1 for a write, bit 2 = 1 for user mode, bit 3 = 1 for a fetch, and bits 6..4 = 0. A granted access returns an error code of 0. `kind_i` = 2'b11 is handled as a read.
- R9: `ovr_set_i` or `ovr_clr_i` with `ovr_req_user_i` = 0 updates `ovr_flag_o` on the next cycle, and clear wins when both are asserted. With `ovr_req_user_i` = 1, both requests are ignored. A request's decision uses the flag value from before any same-cycle update.
- R10: A request accepted on an edge (`req_valid_i` and `req_ready_o`) produces `resp_valid_o` with its result after that edge. `req_ready_o` = !`resp_valid_o` || `resp_ready_i`. While `resp_valid_o` = 1 and `resp_ready_i` = 0, the response holds.
- R11: `fault_addr_o` takes the virtual address of each accepted faulting request after that edge. It holds its value across grants.
- R12: Reset clears `resp_valid_o`, `resp_fault_o`, `resp_err_o`, `fault_addr_o` and `ovr_flag_o`. A supervisor access to a present supervisor page is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| user_mode_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| kind_i | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| implicit_i | input | 1 | 1 = implicit access |
| vaddr_i | input | ADDR_W | Virtual address |
| pg_present_i | input | 1 | Page present |
| pg_rw_i | input | 1 | Page writable |
| pg_user_i | input | 1 | Page is a user page |
| pg_xd_i | input | 1 | Page execute-disable |
| ctrl_word_i | input | CTRL_W | Control word (bit 21 data prevention, bit 20 execution prevention) |
| nx_en_i | input | 1 | No-execute enable |
| ovr_set_i | input | 1 | Request to set the override flag |
| ovr_clr_i | input | 1 | Request to clear the override flag |
| ovr_req_user_i | input | 1 | Privilege of the flag request, 1 = user |
| ovr_flag_o | output | 1 | Current override flag |
| resp_valid_o | output | 1 | Response valid |
| resp_ready_i | input | 1 | Response consumed |
| resp_fault_o | output | 1 | 1 = page fault, 0 = granted |
| resp_err_o | output | 7 | Fault error code |
| fault_addr_o | output | ADDR_W | Last faulting virtual address |

## Verification
The grant/fault result, its error code and the captured fault address all become visible one clock edge after the request is accepted. An override-flag request also takes effect one edge later. The bench drives stimulus at the falling edge and steps a behavioural model at the rising edge. It compares every output at the next falling edge, so each result is checked in the cycle it is due. `req_ready_o` is checked before the edge, against the model's response state. Stalled responses are checked for holding on every cycle that back-pressure lasts.

// File: rtl/perm_pkg.sv
// Shared types and constants for the permission checker.
// Assumes a 7-bit fault error code whose upper three bits are reserved.
package perm_pkg;
    localparam int ERR_W = 7;

    localparam int ERR_PRESENT = 0;
    localparam int ERR_WRITE   = 1;
    localparam int ERR_USER    = 2;
    localparam int ERR_FETCH   = 3;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic             fault;
        logic [ERR_W-1:0] err;
    } perm_result_t;
endpackage

// File: rtl/perm_decide.sv
// Combinational grant/fault decision for one access.
// Assumes page attributes come from a finished translation; the
// not-present check has priority over every protection rule.
module perm_decide
    import perm_pkg::*;
(
    input  logic         user_mode,
    input  logic [1:0]   kind,
    input  logic         implicit_acc,
    input  logic         present,
    input  logic         writable,
    input  logic         user_page,
    input  logic         exec_dis,
    input  logic         data_prev_en,
    input  logic         exec_prev_en,
    input  logic         nx_en,
    input  logic         ovr_flag,
    output perm_result_t result
);
    logic is_write;
    logic is_fetch;
    logic fault;

    // Classify the access kind; the reserved code is handled as a read.
    always_comb begin
        is_write = (acc_kind_e'(kind) == ACC_WRITE);
        is_fetch = (acc_kind_e'(kind) == ACC_FETCH);
    end

    // Apply the rules in priority order: presence, then mode-specific checks.
    always_comb begin
        fault = 1'b0;
        if (!present) begin
            fault = 1'b1;
        end else if (user_mode) begin
            if (!user_page)                       fault = 1'b1;
            else if (is_write && !writable)       fault = 1'b1;
            else if (is_fetch && nx_en && exec_dis) fault = 1'b1;
        end else if (is_fetch) begin
            fault = (exec_prev_en && user_page) || (nx_en && exec_dis);
        end else begin
            fault = data_prev_en && user_page && (implicit_acc || !ovr_flag);
        end
    end

    // Build the error code; a grant returns zero.
    always_comb begin
        result.fault = fault;
        result.err   = '0;
        if (fault) begin
            result.err[ERR_PRESENT] = present;
            result.err[ERR_WRITE]   = is_write;
            result.err[ERR_USER]    = user_mode;
            result.err[ERR_FETCH]   = is_fetch;
        end
    end
endmodule

// File: rtl/ovr_flag_reg.sv
// Override flag register. Only supervisor requests may change it;
// clear wins over set when both are asserted.
module ovr_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic req_user,
    output logic flag
);
    // Update the flag from privileged requests.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag <= 1'b0;
        else if (!req_user && clr_req) flag <= 1'b0;
        else if (!req_user && set_req) flag <= 1'b1;
    end

    assert_user_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_user && (set_req || clr_req)) |=> $stable(flag));
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_user && clr_req) |=> !flag);
endmodule

// File: rtl/fault_addr_reg.sv
// Captures the virtual address of a faulting access and holds it
// until the next capture. Assumes capture is qualified by acceptance.
module fault_addr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    // Load the address on a fault, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_out <= '0;
        else if (capture) addr_out <= addr_in;
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(addr_out));
    assert_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (addr_out == $past(addr_in)));
endmodule

// File: rtl/sup_perm_check.sv
// Permission check stage: one request per cycle, registered result with
// one cycle of latency behind a valid/ready handshake. Assumes the control
// word carries data prevention and execution prevention at parameter bits.
module sup_perm_check
    import perm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CTRL_W  = 32,
    parameter int DPE_BIT = 21,
    parameter int EPE_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              user_mode_i,
    input  logic [1:0]        kind_i,
    input  logic              implicit_i,
    input  logic [ADDR_W-1:0] vaddr_i,
    input  logic              pg_present_i,
    input  logic              pg_rw_i,
    input  logic              pg_user_i,
    input  logic              pg_xd_i,
    input  logic [CTRL_W-1:0] ctrl_word_i,
    input  logic              nx_en_i,
    input  logic              ovr_set_i,
    input  logic              ovr_clr_i,
    input  logic              ovr_req_user_i,
    output logic              ovr_flag_o,
    output logic              resp_valid_o,
    input  logic              resp_ready_i,
    output logic              resp_fault_o,
    output logic [ERR_W-1:0]  resp_err_o,
    output logic [ADDR_W-1:0] fault_addr_o
);
    perm_result_t decision;
    logic         accept;
    logic         ctrl_unused;

    assign ctrl_unused = ^ctrl_word_i;
    assign req_ready_o = !resp_valid_o || resp_ready_i;
    assign accept      = req_valid_i && req_ready_o;

    perm_decide u_decide (
        .user_mode    (user_mode_i),
        .kind         (kind_i),
        .implicit_acc (implicit_i),
        .present      (pg_present_i),
        .writable     (pg_rw_i),
        .user_page    (pg_user_i),
        .exec_dis     (pg_xd_i),
        .data_prev_en (ctrl_word_i[DPE_BIT]),
        .exec_prev_en (ctrl_word_i[EPE_BIT]),
        .nx_en        (nx_en_i),
        .ovr_flag     (ovr_flag_o),
        .result       (decision)
    );

    ovr_flag_reg u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (ovr_set_i),
        .clr_req  (ovr_clr_i),
        .req_user (ovr_req_user_i),
        .flag     (ovr_flag_o)
    );

    fault_addr_reg #(.ADDR_W(ADDR_W)) u_faddr (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept && decision.fault),
        .addr_in  (vaddr_i),
        .addr_out (fault_addr_o)
    );

    // Response register: load on accept, drop when consumed, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_o <= 1'b0;
            resp_fault_o <= 1'b0;
            resp_err_o   <= '0;
        end else if (req_ready_o) begin
            resp_valid_o <= req_valid_i;
            if (accept) begin
                resp_fault_o <= decision.fault;
                resp_err_o   <= decision.err;
            end
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && !resp_ready_i) |=>
            (resp_valid_o && $stable(resp_fault_o) && $stable(resp_err_o)));
    assert_not_present_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pg_present_i) |=> (resp_fault_o && !resp_err_o[ERR_PRESENT]));
    assert_implicit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !user_mode_i && implicit_i && kind_i != 2'b10 && pg_present_i
         && pg_user_i && ctrl_word_i[DPE_BIT]) |=> resp_fault_o);
    assert_exec_prev_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !user_mode_i && kind_i == 2'b10 && pg_present_i && pg_user_i
         && ctrl_word_i[EPE_BIT]) |=> (resp_fault_o && resp_err_o[ERR_FETCH]));
endmodule

// File: tb/test_sup_perm_check.sv
`timescale 1ns/1ps
module test_sup_perm_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic        user_mode_i = 1'b0;
    logic [1:0]  kind_i = 2'b00;
    logic        implicit_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic        pg_present_i = 1'b0, pg_rw_i = 1'b0, pg_user_i = 1'b0, pg_xd_i = 1'b0;
    logic [31:0] ctrl_word_i = '0;
    logic        nx_en_i = 1'b0;
    logic        ovr_set_i = 1'b0, ovr_clr_i = 1'b0, ovr_req_user_i = 1'b0;
    logic        ovr_flag_o;
    logic        resp_valid_o;
    logic        resp_ready_i = 1'b1;
    logic        resp_fault_o;
    logic [6:0]  resp_err_o;
    logic [31:0] fault_addr_o;

    int checks = 0;
    int fails  = 0;

    // Reference state
    logic        m_valid = 0, m_fault = 0, m_ovr = 0;
    logic [6:0]  m_err = 0;
    logic [31:0] m_addr = 0;

    always #2.5 clk = ~clk;

    sup_perm_check i_sup_perm_check (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .user_mode_i(user_mode_i), .kind_i(kind_i), .implicit_i(implicit_i),
        .vaddr_i(vaddr_i), .pg_present_i(pg_present_i), .pg_rw_i(pg_rw_i),
        .pg_user_i(pg_user_i), .pg_xd_i(pg_xd_i), .ctrl_word_i(ctrl_word_i),
        .nx_en_i(nx_en_i), .ovr_set_i(ovr_set_i), .ovr_clr_i(ovr_clr_i),
        .ovr_req_user_i(ovr_req_user_i), .ovr_flag_o(ovr_flag_o),
        .resp_valid_o(resp_valid_o), .resp_ready_i(resp_ready_i),
        .resp_fault_o(resp_fault_o), .resp_err_o(resp_err_o), .fault_addr_o(fault_addr_o)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural expectation: {fault, err} for the current inputs.
    function automatic logic [7:0] expect_result();
        logic wr = (kind_i == 2'b01);
        logic fe = (kind_i == 2'b10);
        logic bad;
        if (!pg_present_i)            bad = 1;
        else if (user_mode_i)         bad = !pg_user_i || (wr && !pg_rw_i) || (fe && nx_en_i && pg_xd_i);
        else if (fe)                  bad = (ctrl_word_i[20] && pg_user_i) || (nx_en_i && pg_xd_i);
        else                          bad = ctrl_word_i[21] && pg_user_i && (implicit_i || !m_ovr);
        if (!bad) return 8'h00;
        return {1'b1, 3'b000, fe, user_mode_i, wr, pg_present_i};
    endfunction

    task automatic step(input string tag);
        logic [7:0] r;
        logic rdy;
        #1;
        rdy = !m_valid || resp_ready_i;
        check("R10", "req_ready", req_ready_o, rdy);
        r = expect_result();
        @(posedge clk);
        if (rdy) begin
            m_valid = req_valid_i;
            if (req_valid_i) begin
                m_fault = r[7];
                m_err   = r[6:0];
                if (r[7]) m_addr = vaddr_i;
            end
        end
        if (!ovr_req_user_i && ovr_clr_i)      m_ovr = 0;
        else if (!ovr_req_user_i && ovr_set_i) m_ovr = 1;
        @(negedge clk);
        check(tag, "resp_valid", resp_valid_o, m_valid);
        check(tag, "resp_fault", resp_fault_o, m_fault);
        check(tag, "resp_err",   resp_err_o,   m_err);
        check("R11", "fault_addr", fault_addr_o, m_addr);
        check("R9",  "ovr_flag",   ovr_flag_o,   m_ovr);
    endtask

    task automatic req(input logic um, input logic [1:0] k, input logic imp, input logic [31:0] a,
                       input logic p, input logic rw, input logic us, input logic xd,
                       input logic [31:0] cw, input logic nx, input string tag);
        req_valid_i = 1; user_mode_i = um; kind_i = k; implicit_i = imp; vaddr_i = a;
        pg_present_i = p; pg_rw_i = rw; pg_user_i = us; pg_xd_i = xd;
        ctrl_word_i = cw; nx_en_i = nx;
        ovr_set_i = 0; ovr_clr_i = 0; ovr_req_user_i = 0; resp_ready_i = 1;
        step(tag);
    endtask

    task automatic flag_req(input logic s, input logic c, input logic u, input string tag);
        req_valid_i = 0; ovr_set_i = s; ovr_clr_i = c; ovr_req_user_i = u;
        step(tag);
        ovr_set_i = 0; ovr_clr_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        localparam logic [31:0] DPE = 32'h0020_0000;
        localparam logic [31:0] EPE = 32'h0010_0000;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "resp_valid", resp_valid_o, 0);
        check("R12", "resp_err", resp_err_o, 0);
        check("R12", "fault_addr", fault_addr_o, 0);
        check("R12", "ovr_flag", ovr_flag_o, 0);
        rst_n = 1;
        req(0, 2'b00, 0, 32'h100, 1, 1, 0, 0, DPE | EPE, 1, "R12");
        req(1, 2'b01, 0, 32'hA000, 0, 1, 1, 0, DPE, 0, "R1");       // err 6
        check("R1", "err", resp_err_o, 7'h06);
        req(0, 2'b10, 1, 32'hA004, 0, 0, 1, 1, DPE | EPE, 1, "R1"); // err 8
        req(1, 2'b00, 0, 32'hB000, 1, 1, 0, 0, 0, 0, "R2");         // err 5
        check("R2", "err", resp_err_o, 7'h05);
        req(1, 2'b01, 0, 32'hB004, 1, 0, 1, 0, 0, 0, "R2");         // err 7
        req(1, 2'b01, 0, 32'hB008, 1, 1, 1, 0, DPE, 0, "R2");       // grant
        req(0, 2'b00, 0, 32'hC000, 1, 0, 1, 0, 0, 0, "R3");
        req(0, 2'b01, 1, 32'hC004, 1, 1, 1, 0, EPE, 0, "R3");
        req(0, 2'b00, 0, 32'hD000, 1, 1, 1, 0, DPE, 0, "R4");       // err 1
        check("R8", "err", resp_err_o, 7'h01);
        req(0, 2'b01, 0, 32'hD004, 1, 1, 1, 0, DPE, 0, "R4");       // err 3
        check("R8", "err", resp_err_o, 7'h03);
        req(0, 2'b11, 0, 32'hD008, 1, 1, 1, 0, DPE, 0, "R8");       // reserved -> read
        flag_req(1, 0, 1, "R9");                                     // ignored
        check("R9", "user set ignored", ovr_flag_o, 0);
        flag_req(1, 0, 0, "R9");
        check("R9", "supervisor set", ovr_flag_o, 1);
        req(0, 2'b00, 0, 32'hD00C, 1, 1, 1, 0, DPE, 0, "R4");       // granted
        req(0, 2'b01, 1, 32'hE000, 1, 1, 1, 0, DPE, 0, "R5");       // faults
        req(0, 2'b00, 1, 32'hE004, 1, 1, 1, 0, DPE, 0, "R5");
        flag_req(0, 1, 1, "R9");
        check("R9", "user clear ignored", ovr_flag_o, 1);
        flag_req(1, 1, 0, "R9");
        check("R9", "clear wins", ovr_flag_o, 0);
        req(0, 2'b10, 0, 32'hF000, 1, 1, 1, 0, EPE, 0, "R6");       // err 9
        check("R6", "err", resp_err_o, 7'h09);
        req(0, 2'b10, 0, 32'hF004, 1, 1, 1, 0, DPE, 0, "R6");       // grant
        req(0, 2'b10, 0, 32'hF008, 1, 1, 0, 1, 0, 1, "R7");
        req(1, 2'b10, 0, 32'hF00C, 1, 1, 1, 1, 0, 1, "R7");         // err 13
        check("R7", "err", resp_err_o, 7'h0D);
        req(1, 2'b10, 0, 32'hF010, 1, 1, 1, 1, 0, 0, "R7");         // grant
        req(0, 2'b00, 0, 32'h1234, 1, 1, 0, 0, 0, 0, "R11");
        check("R11", "held", fault_addr_o, 32'hF00C);
        // R10: stall keeps the response
        req(0, 2'b00, 0, 32'h5000, 0, 0, 0, 0, 0, 0, "R10");
        resp_ready_i = 0; req_valid_i = 1; vaddr_i = 32'h6000; pg_present_i = 1;
        step("R10");
        step("R10");
        check("R10", "held addr", fault_addr_o, 32'h5000);
        resp_ready_i = 1;
        step("R10");
        // Random traffic with back-pressure
        for (int i = 0; i < 600; i++) begin
            req_valid_i = $urandom_range(0, 3) != 0;
            user_mode_i = $urandom_range(0, 1);
            kind_i = 2'($urandom_range(0, 3));
            implicit_i = $urandom_range(0, 1);
            vaddr_i = $urandom;
            pg_present_i = $urandom_range(0, 7) != 0;
            pg_rw_i = $urandom_range(0, 1);
            pg_user_i = $urandom_range(0, 1);
            pg_xd_i = $urandom_range(0, 1);
            ctrl_word_i = $urandom;
            nx_en_i = $urandom_range(0, 1);
            ovr_set_i = $urandom_range(0, 3) == 0;
            ovr_clr_i = $urandom_range(0, 3) == 0;
            ovr_req_user_i = $urandom_range(0, 1);
            resp_ready_i = $urandom_range(0, 3) != 0;
            step("R10");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule